// File: doc/BRIEF.md
# Endian-Aware Module Space Decoder

This block sits between a host-side local bus and a carrier of up to four plug-in modules. Host accesses arrive in one of four windows: a 16-bit control window, a 1 KiB module I/O window, a 32 MiB window for 16-bit module memory and a 16 MiB window for 8-bit module memory. In the same cycle as the access, the decoder turns each one into a module bus request. The request carries a slot number, a sub-space select, a masked offset and data whose byte lanes have been corrected.

Each of the first three windows can run in big-endian mode. For a byte access in that mode, the decoder flips the low address bit. For a 16-bit access in that mode, it exchanges the two data bytes in both directions. The three mode bits are held in the decoder. Software sets them through a byte-wide configuration port, whose read side otherwise returns a constant table supplied on an input.

Reads in a module's interrupt space also acknowledge that module's level-sensitive interrupt lines. Accesses that target an empty slot are dropped, and so are accesses of a size the window does not accept.

Top module: `mod_space_decoder`

## Requirements
- R1: I/O window (host_win_i=1) decoding:
  - slot = addr[9:8].
  - Field addr[7:6] selects the sub-space: 2 gives ID space (mod_space_o=1) with offset addr[5:0]; 3 gives interrupt space (mod_space_o=2) with offset addr[5:0]; 0 and 1 give I/O space (mod_space_o=0) with offset addr[6:0].
- R2: Memory window decoding:
  - 16-bit memory window (host_win_i=2, mod_space_o=3): slot = addr[24:23], offset = addr[22:0].
  - 8-bit memory window (host_win_i=3, mod_space_o=4): slot = addr[23:22], offset = addr[21:0].
- R3: When the I/O window or the 16-bit memory window is in big-endian mode and the access is 8-bit (host_size16_i=0), address bit 0 is inverted before decoding.
- R4: Byte swapping on 16-bit accesses:
  - In big-endian mode, a 16-bit access to the control, I/O or 16-bit memory window swaps the two bytes of the write data sent out and of the read data returned.
  - The 8-bit memory window never swaps.
- R5: Access sizes:
  - The control window accepts only 16-bit accesses.
  - The 8-bit memory window accepts only 8-bit accesses.
  - The other two windows accept both sizes.
  - A rejected access raises no request and reads 0.
- R6: Interrupt acknowledge:
  - A read in interrupt space at offset 0 pulses irq_ack_o[2*slot] in the same cycle, and a read at offset 2 pulses irq_ack_o[2*slot+1].
  - The pulse is given only when the line's irq_status_i bit is 1 and its irq_edge_i bit is 0.
  - Writes and other offsets never acknowledge.
- R7: Empty slots and idle cycles:
  - An access to a slot whose slot_present_i bit is 0 raises no module request, gives no acknowledge and reads 0.
  - With host_req_i low, no request is raised and host_rdata_o is 0.
  - A write always returns host_rdata_o = 0.
- R8: Mode bit writes:
  - A configuration write stores cfg_wdata_i[0] as a mode bit at byte 0x2B (control window), 0x2F (I/O window) or 0x33 (16-bit memory window). In each case the write lands on the next clock.
  - Writes to any other configuration byte change nothing.
- R9: Configuration reads:
  - A read of byte k returns cfg_table_i[8k+7:8k] for k below the table size (88 bytes by default), and 0 past the table.
  - At the three mode bytes, bit 0 is ORed with the stored mode bit.
- R10: Reset clears all three mode bits, so every window starts little-endian.
- R11: A legal control-window access raises ctrl_req_o with ctrl_addr_o = addr[7:0] and returns ctrl_rdata_i as its read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_i | input | 1 | Host access valid this cycle |
| host_win_i | input | 2 | Window: 0 control, 1 I/O, 2 16-bit memory, 3 8-bit memory |
| host_we_i | input | 1 | 1 for write |
| host_size16_i | input | 1 | 1 for a 16-bit access, 0 for 8-bit |
| host_addr_i | input | 25 | Byte address inside the window |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Host read data |
| ctrl_req_o | output | 1 | Control register access |
| ctrl_we_o | output | 1 | Control access is a write |
| ctrl_addr_o | output | 8 | Control byte address |
| ctrl_wdata_o | output | 16 | Lane-corrected control write data |
| ctrl_rdata_i | input | 16 | Control read data |
| mod_req_o | output | 1 | Module bus request |
| mod_we_o | output | 1 | Module access is a write |
| mod_size16_o | output | 1 | Module access is 16-bit |
| mod_slot_o | output | 2 | Target slot |
| mod_space_o | output | 3 | 0 I/O, 1 ID, 2 interrupt, 3 16-bit memory, 4 8-bit memory |
| mod_offset_o | output | 23 | Masked offset in the sub-space |
| mod_wdata_o | output | 16 | Lane-corrected module write data |
| mod_rdata_i | input | 16 | Module read data |
| slot_present_i | input | 4 | Slot occupied, one bit per slot |
| irq_status_i | input | 8 | Pending interrupt lines, bit 2*slot+n |
| irq_edge_i | input | 8 | Line configured edge-sensitive |
| irq_ack_o | output | 8 | Acknowledge pulse per line |
| cfg_we_i | input | 1 | Configuration byte write |
| cfg_addr_i | input | 7 | Configuration byte address |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data |
| cfg_table_i | input | 704 | Constant configuration table, byte k at bits 8k+7:8k |

## Verification
On every cycle, the assertions check the following:
- A module request only ever goes to an occupied slot.
- Size-illegal requests never appear.
- Acknowledge pulses are at most one-hot. They come only from reads in the I/O window, and never land on an edge-configured or non-pending line.
- Mode bits hold unless their own configuration byte is written.
- Idle cycles read zero.

The exact address arithmetic is left to the bench scenarios, which compare every output against a behavioural model. That covers:
- the slot and offset split in each window;
- the big-endian address flip that moves an interrupt-space read onto offset 0;
- byte swaps in both directions;
- the table read with its OR-ed mode bits.

// File: rtl/msd_pkg.sv
package msd_pkg;
  typedef enum logic [1:0] {
    WIN_CTRL  = 2'd0,
    WIN_IO    = 2'd1,
    WIN_MEM16 = 2'd2,
    WIN_MEM8  = 2'd3
  } win_e;

  typedef enum logic [2:0] {
    SP_IO    = 3'd0,
    SP_ID    = 3'd1,
    SP_INT   = 3'd2,
    SP_MEM16 = 3'd3,
    SP_MEM8  = 3'd4
  } space_e;

  localparam int unsigned NUM_BE_WIN = 3;
  localparam logic [7:0]  MODE_BASE   = 8'h2B;
  localparam int unsigned MODE_STRIDE = 4;

  function automatic logic [15:0] bswap16(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction
endpackage

// File: rtl/msd_cfg_regs.sv
module msd_cfg_regs
  import msd_pkg::*;
#(
  parameter int unsigned CFG_BYTES = 88,
  parameter int unsigned CFG_AW    = 7
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_we_i,
  input  logic [CFG_AW-1:0]      cfg_addr_i,
  input  logic [7:0]             cfg_wdata_i,
  input  logic [CFG_BYTES*8-1:0] cfg_table_i,
  output logic [7:0]             cfg_rdata_o,
  output logic [NUM_BE_WIN-1:0]  mode_o
);
  logic [NUM_BE_WIN-1:0] mode_q;
  logic [NUM_BE_WIN-1:0] mode_hit;
  logic [6:0]            unused_wdata;

  assign unused_wdata = cfg_wdata_i[7:1];

  for (genvar w = 0; w < NUM_BE_WIN; w++) begin : g_mode
    localparam logic [CFG_AW-1:0] MODE_ADDR = CFG_AW'(MODE_BASE + MODE_STRIDE * w);
    assign mode_hit[w] = (cfg_addr_i == MODE_ADDR);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mode_q[w] <= 1'b0;
      end else if (cfg_we_i && mode_hit[w]) begin
        mode_q[w] <= cfg_wdata_i[0];
      end
    end
  end

  always_comb begin
    cfg_rdata_o = '0;
    if (32'(cfg_addr_i) < CFG_BYTES) begin
      cfg_rdata_o = cfg_table_i[32'(cfg_addr_i)*8 +: 8];
    end
    cfg_rdata_o[0] = cfg_rdata_o[0] | (|(mode_hit & mode_q));
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/msd_lane_adj.sv
module msd_lane_adj
  import msd_pkg::*;
(
  input  logic        be_i,
  input  logic        size16_i,
  input  logic        addr_lsb_i,
  input  logic [15:0] wdata_i,
  input  logic [15:0] rdata_i,
  output logic        addr_lsb_o,
  output logic [15:0] wdata_o,
  output logic [15:0] rdata_o
);
  logic flip_addr;
  logic swap_data;

  assign flip_addr  = be_i && !size16_i;
  assign swap_data  = be_i && size16_i;
  assign addr_lsb_o = addr_lsb_i ^ flip_addr;
  assign wdata_o    = swap_data ? bswap16(wdata_i) : wdata_i;
  assign rdata_o    = swap_data ? bswap16(rdata_i) : rdata_i;
endmodule

// File: rtl/msd_win_decode.sv
module msd_win_decode
  import msd_pkg::*;
#(
  parameter int unsigned SLOT_W         = 2,
  parameter int unsigned IO_SLOT_LSB    = 8,
  parameter int unsigned MEM16_SLOT_LSB = 23,
  parameter int unsigned MEM8_SLOT_LSB  = 22,
  localparam int unsigned ADDR_W        = MEM16_SLOT_LSB + SLOT_W,
  localparam int unsigned OFF_W         = MEM16_SLOT_LSB
) (
  input  win_e              win_i,
  input  logic              size16_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              legal_o,
  output logic [SLOT_W-1:0] slot_o,
  output space_e            space_o,
  output logic [OFF_W-1:0]  offset_o,
  output logic              int_hit_o,
  output logic              intno_o
);
  localparam int unsigned IO_OFF_W  = IO_SLOT_LSB - 1;
  localparam int unsigned SUB_OFF_W = IO_SLOT_LSB - 2;

  logic [1:0] sub_sel;
  assign sub_sel = addr_i[IO_SLOT_LSB-1 -: 2];

  always_comb begin
    legal_o  = 1'b1;
    slot_o   = '0;
    space_o  = SP_IO;
    offset_o = '0;
    unique case (win_i)
      WIN_CTRL: begin
        legal_o = size16_i;
      end
      WIN_IO: begin
        slot_o = addr_i[IO_SLOT_LSB +: SLOT_W];
        unique case (sub_sel)
          2'd2: begin
            space_o  = SP_ID;
            offset_o = OFF_W'(addr_i[SUB_OFF_W-1:0]);
          end
          2'd3: begin
            space_o  = SP_INT;
            offset_o = OFF_W'(addr_i[SUB_OFF_W-1:0]);
          end
          default: begin
            space_o  = SP_IO;
            offset_o = OFF_W'(addr_i[IO_OFF_W-1:0]);
          end
        endcase
      end
      WIN_MEM16: begin
        slot_o   = addr_i[MEM16_SLOT_LSB +: SLOT_W];
        space_o  = SP_MEM16;
        offset_o = OFF_W'(addr_i[MEM16_SLOT_LSB-1:0]);
      end
      default: begin
        legal_o  = !size16_i;
        slot_o   = addr_i[MEM8_SLOT_LSB +: SLOT_W];
        space_o  = SP_MEM8;
        offset_o = OFF_W'(addr_i[MEM8_SLOT_LSB-1:0]);
      end
    endcase
  end

  // acknowledge offsets 0 and 2 only
  assign int_hit_o = (space_o == SP_INT) && (offset_o[OFF_W-1:2] == '0) && !offset_o[0];
  assign intno_o   = offset_o[1];
endmodule

// File: rtl/msd_irq_ack.sv
module msd_irq_ack #(
  parameter int unsigned SLOT_W     = 2,
  localparam int unsigned NUM_SLOTS = 1 << SLOT_W,
  localparam int unsigned NUM_LINES = 2 * NUM_SLOTS
) (
  input  logic                 fire_i,
  input  logic [SLOT_W-1:0]    slot_i,
  input  logic                 intno_i,
  input  logic [NUM_LINES-1:0] status_i,
  input  logic [NUM_LINES-1:0] edge_i,
  output logic [NUM_LINES-1:0] ack_o
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    for (genvar n = 0; n < 2; n++) begin : g_line
      localparam int unsigned LINE = 2 * s + n;
      assign ack_o[LINE] = fire_i && (slot_i == SLOT_W'(s)) && (intno_i == 1'(n))
                           && status_i[LINE] && !edge_i[LINE];
    end
  end
endmodule

// File: rtl/mod_space_decoder.sv
module mod_space_decoder
  import msd_pkg::*;
#(
  parameter int unsigned SLOT_W         = 2,
  parameter int unsigned IO_SLOT_LSB    = 8,
  parameter int unsigned MEM16_SLOT_LSB = 23,
  parameter int unsigned MEM8_SLOT_LSB  = 22,
  parameter int unsigned CTRL_AW        = 8,
  parameter int unsigned CFG_BYTES      = 88,
  parameter int unsigned CFG_AW         = 7,
  localparam int unsigned NUM_SLOTS     = 1 << SLOT_W,
  localparam int unsigned NUM_LINES     = 2 * NUM_SLOTS,
  localparam int unsigned ADDR_W        = MEM16_SLOT_LSB + SLOT_W,
  localparam int unsigned OFF_W         = MEM16_SLOT_LSB
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   host_req_i,
  input  logic [1:0]             host_win_i,
  input  logic                   host_we_i,
  input  logic                   host_size16_i,
  input  logic [ADDR_W-1:0]      host_addr_i,
  input  logic [15:0]            host_wdata_i,
  output logic [15:0]            host_rdata_o,
  output logic                   ctrl_req_o,
  output logic                   ctrl_we_o,
  output logic [CTRL_AW-1:0]     ctrl_addr_o,
  output logic [15:0]            ctrl_wdata_o,
  input  logic [15:0]            ctrl_rdata_i,
  output logic                   mod_req_o,
  output logic                   mod_we_o,
  output logic                   mod_size16_o,
  output logic [SLOT_W-1:0]      mod_slot_o,
  output logic [2:0]             mod_space_o,
  output logic [OFF_W-1:0]       mod_offset_o,
  output logic [15:0]            mod_wdata_o,
  input  logic [15:0]            mod_rdata_i,
  input  logic [NUM_SLOTS-1:0]   slot_present_i,
  input  logic [NUM_LINES-1:0]   irq_status_i,
  input  logic [NUM_LINES-1:0]   irq_edge_i,
  output logic [NUM_LINES-1:0]   irq_ack_o,
  input  logic                   cfg_we_i,
  input  logic [CFG_AW-1:0]      cfg_addr_i,
  input  logic [7:0]             cfg_wdata_i,
  output logic [7:0]             cfg_rdata_o,
  input  logic [CFG_BYTES*8-1:0] cfg_table_i
);
  win_e                  win;
  logic [NUM_BE_WIN-1:0] win_mode;
  logic [3:0]            win_be_vec;
  logic                  win_be;
  logic                  addr_lsb_adj;
  logic [ADDR_W-1:0]     addr_adj;
  logic [15:0]           wdata_adj;
  logic [15:0]           rdata_raw;
  logic                  dec_legal;
  logic [SLOT_W-1:0]     dec_slot;
  space_e                dec_space;
  logic [OFF_W-1:0]      dec_offset;
  logic                  dec_int_hit;
  logic                  dec_intno;
  logic                  is_ctrl;
  logic                  mod_go;
  logic                  ctrl_go;
  logic                  ack_fire;

  assign win = win_e'(host_win_i);

  msd_cfg_regs #(
    .CFG_BYTES (CFG_BYTES),
    .CFG_AW    (CFG_AW)
  ) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_table_i (cfg_table_i),
    .cfg_rdata_o (cfg_rdata_o),
    .mode_o      (win_mode)
  );

  // windows without a mode bit stay little-endian
  for (genvar w = 0; w < 4; w++) begin : g_be
    if (w < NUM_BE_WIN) begin : g_has_mode
      assign win_be_vec[w] = win_mode[w];
    end else begin : g_no_mode
      assign win_be_vec[w] = 1'b0;
    end
  end
  assign win_be = win_be_vec[host_win_i];

  msd_lane_adj u_lane (
    .be_i       (win_be),
    .size16_i   (host_size16_i),
    .addr_lsb_i (host_addr_i[0]),
    .wdata_i    (host_wdata_i),
    .rdata_i    (rdata_raw),
    .addr_lsb_o (addr_lsb_adj),
    .wdata_o    (wdata_adj),
    .rdata_o    (host_rdata_o)
  );

  assign addr_adj = {host_addr_i[ADDR_W-1:1], addr_lsb_adj};

  msd_win_decode #(
    .SLOT_W         (SLOT_W),
    .IO_SLOT_LSB    (IO_SLOT_LSB),
    .MEM16_SLOT_LSB (MEM16_SLOT_LSB),
    .MEM8_SLOT_LSB  (MEM8_SLOT_LSB)
  ) u_dec (
    .win_i     (win),
    .size16_i  (host_size16_i),
    .addr_i    (addr_adj),
    .legal_o   (dec_legal),
    .slot_o    (dec_slot),
    .space_o   (dec_space),
    .offset_o  (dec_offset),
    .int_hit_o (dec_int_hit),
    .intno_o   (dec_intno)
  );

  assign is_ctrl  = (win == WIN_CTRL);
  assign ctrl_go  = host_req_i && dec_legal && is_ctrl;
  assign mod_go   = host_req_i && dec_legal && !is_ctrl && slot_present_i[dec_slot];
  assign ack_fire = mod_go && !host_we_i && dec_int_hit;

  msd_irq_ack #(
    .SLOT_W (SLOT_W)
  ) u_ack (
    .fire_i   (ack_fire),
    .slot_i   (dec_slot),
    .intno_i  (dec_intno),
    .status_i (irq_status_i),
    .edge_i   (irq_edge_i),
    .ack_o    (irq_ack_o)
  );

  always_comb begin
    rdata_raw = '0;
    if (!host_we_i) begin
      if (ctrl_go) begin
        rdata_raw = ctrl_rdata_i;
      end else if (mod_go) begin
        rdata_raw = mod_rdata_i;
      end
    end
  end

  assign ctrl_req_o   = ctrl_go;
  assign ctrl_we_o    = host_we_i;
  assign ctrl_addr_o  = host_addr_i[CTRL_AW-1:0];
  assign ctrl_wdata_o = wdata_adj;

  assign mod_req_o    = mod_go;
  assign mod_we_o     = host_we_i;
  assign mod_size16_o = host_size16_i;
  assign mod_slot_o   = dec_slot;
  assign mod_space_o  = dec_space;
  assign mod_offset_o = dec_offset;
  assign mod_wdata_o  = wdata_adj;
endmodule

// File: rtl/msd_checker.sv
module msd_checker
  import msd_pkg::*;
#(
  parameter int unsigned SLOT_W        = 2,
  parameter int unsigned MEM8_SLOT_LSB = 22,
  parameter int unsigned OFF_W         = 23,
  parameter int unsigned CFG_AW        = 7,
  localparam int unsigned NUM_SLOTS    = 1 << SLOT_W,
  localparam int unsigned NUM_LINES    = 2 * NUM_SLOTS
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  host_req_i,
  input logic [1:0]            host_win_i,
  input logic                  host_we_i,
  input logic                  host_size16_i,
  input logic [15:0]           host_rdata_o,
  input logic                  ctrl_req_o,
  input logic                  mod_req_o,
  input logic                  mod_size16_o,
  input logic [SLOT_W-1:0]     mod_slot_o,
  input logic [2:0]            mod_space_o,
  input logic [OFF_W-1:0]      mod_offset_o,
  input logic [NUM_SLOTS-1:0]  slot_present_i,
  input logic [NUM_LINES-1:0]  irq_status_i,
  input logic [NUM_LINES-1:0]  irq_edge_i,
  input logic [NUM_LINES-1:0]  irq_ack_o,
  input logic                  cfg_we_i,
  input logic [CFG_AW-1:0]     cfg_addr_i,
  input logic [NUM_BE_WIN-1:0] win_mode
);
  logic mode_byte;
  assign mode_byte = (cfg_addr_i == CFG_AW'(MODE_BASE))
                  || (cfg_addr_i == CFG_AW'(MODE_BASE + MODE_STRIDE))
                  || (cfg_addr_i == CFG_AW'(MODE_BASE + 2 * MODE_STRIDE));

  assert_req_present_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_req_o |-> slot_present_i[mod_slot_o]);

  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_req_i |-> (!mod_req_o && !ctrl_req_o && host_rdata_o == 16'h0));

  assert_mem8_size_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_req_o && mod_space_o == 3'd4) |-> !mod_size16_o);

  assert_ctrl_size_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_req_o |-> host_size16_i);

  assert_mem8_offset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_req_o && mod_space_o == 3'd4) |-> (mod_offset_o[OFF_W-1:MEM8_SLOT_LSB] == '0));

  assert_ack_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_ack_o));

  assert_ack_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_o & (irq_edge_i | ~irq_status_i)) == '0);

  assert_ack_on_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_ack_o) |-> (host_req_i && !host_we_i && host_win_i == 2'd1 && mod_req_o));

  assert_mode_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_we_i && mode_byte) |=> (win_mode == $past(win_mode)));
endmodule

bind mod_space_decoder msd_checker #(
  .SLOT_W        (SLOT_W),
  .MEM8_SLOT_LSB (MEM8_SLOT_LSB),
  .OFF_W         (OFF_W),
  .CFG_AW        (CFG_AW)
) u_msd_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .host_req_i     (host_req_i),
  .host_win_i     (host_win_i),
  .host_we_i      (host_we_i),
  .host_size16_i  (host_size16_i),
  .host_rdata_o   (host_rdata_o),
  .ctrl_req_o     (ctrl_req_o),
  .mod_req_o      (mod_req_o),
  .mod_size16_o   (mod_size16_o),
  .mod_slot_o     (mod_slot_o),
  .mod_space_o    (mod_space_o),
  .mod_offset_o   (mod_offset_o),
  .slot_present_i (slot_present_i),
  .irq_status_i   (irq_status_i),
  .irq_edge_i     (irq_edge_i),
  .irq_ack_o      (irq_ack_o),
  .cfg_we_i       (cfg_we_i),
  .cfg_addr_i     (cfg_addr_i),
  .win_mode       (win_mode)
);

// File: tb/tb_mod_space_decoder.sv
`timescale 1ns/1ps
module tb_mod_space_decoder;
  localparam int CFG_BYTES = 88;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         host_req_i = 1'b0;
  logic [1:0]   host_win_i = '0;
  logic         host_we_i = 1'b0;
  logic         host_size16_i = 1'b0;
  logic [24:0]  host_addr_i = '0;
  logic [15:0]  host_wdata_i = '0;
  logic [15:0]  host_rdata_o;
  logic         ctrl_req_o, ctrl_we_o;
  logic [7:0]   ctrl_addr_o;
  logic [15:0]  ctrl_wdata_o;
  logic [15:0]  ctrl_rdata_i = 16'hBEEF;
  logic         mod_req_o, mod_we_o, mod_size16_o;
  logic [1:0]   mod_slot_o;
  logic [2:0]   mod_space_o;
  logic [22:0]  mod_offset_o;
  logic [15:0]  mod_wdata_o;
  logic [15:0]  mod_rdata_i = 16'hA55A;
  logic [3:0]   slot_present_i = 4'hF;
  logic [7:0]   irq_status_i = '0;
  logic [7:0]   irq_edge_i = '0;
  logic [7:0]   irq_ack_o;
  logic         cfg_we_i = 1'b0;
  logic [6:0]   cfg_addr_i = 7'h2B;
  logic [7:0]   cfg_wdata_i = '0;
  logic [7:0]   cfg_rdata_o;
  logic [CFG_BYTES*8-1:0] cfg_table_i;

  int n_cmp = 0;
  int n_bad = 0;
  int m_mode[3] = '{0, 0, 0};

  always #4 clk_i = ~clk_i;

  initial begin
    for (int k = 0; k < CFG_BYTES; k++) cfg_table_i[k*8 +: 8] = 8'((k * 7 + 3) & 255);
  end

  mod_space_decoder dut (.*);

  function automatic int bsw(int v);
    return ((v & 255) << 8) | ((v >> 8) & 255);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference for every output, checked between clock edges
  task automatic compare(string tag);
    int win, adr, b, legal, slot, sf, sp, off, mreq, creq, sw, raw, ack, idx, ca, cexp;
    win = host_win_i;
    adr = int'(host_addr_i);
    b = (win < 3) ? m_mode[win] : 0;
    if (b != 0 && !host_size16_i) adr = adr ^ 1;
    legal = (win == 0) ? int'(host_size16_i) : (win == 3) ? int'(!host_size16_i) : 1;
    slot = 0; sp = 0; off = 0;
    if (win == 1) begin
      slot = (adr >> 8) & 3;
      sf = (adr >> 6) & 3;
      sp = (sf == 2) ? 1 : (sf == 3) ? 2 : 0;
      off = (sf >= 2) ? (adr & 63) : (adr & 127);
    end else if (win == 2) begin
      slot = (adr >> 23) & 3; sp = 3; off = adr & 'h7FFFFF;
    end else if (win == 3) begin
      slot = (adr >> 22) & 3; sp = 4; off = adr & 'h3FFFFF;
    end
    mreq = (host_req_i && legal != 0 && win != 0 && slot_present_i[slot]) ? 1 : 0;
    creq = (host_req_i && legal != 0 && win == 0) ? 1 : 0;
    sw = (b != 0 && host_size16_i) ? 1 : 0;
    raw = 0;
    if (!host_we_i) raw = (creq != 0) ? int'(ctrl_rdata_i) : (mreq != 0) ? int'(mod_rdata_i) : 0;
    ack = 0;
    if (mreq != 0 && !host_we_i && sp == 2 && (off == 0 || off == 2)) begin
      idx = slot * 2 + off / 2;
      if (irq_status_i[idx] && !irq_edge_i[idx]) ack = 1 << idx;
    end
    chk(tag, "mod_req", int'(mod_req_o), mreq);
    chk(tag, "ctrl_req", int'(ctrl_req_o), creq);
    if (mreq != 0) begin
      chk(tag, "mod_slot", int'(mod_slot_o), slot);
      chk(tag, "mod_space", int'(mod_space_o), sp);
      chk(tag, "mod_offset", int'(mod_offset_o), off);
      chk(tag, "mod_we", int'(mod_we_o), int'(host_we_i));
      if (host_we_i) chk(tag, "mod_wdata", int'(mod_wdata_o), sw != 0 ? bsw(int'(host_wdata_i)) : int'(host_wdata_i));
    end
    if (creq != 0) begin
      chk(tag, "ctrl_addr", int'(ctrl_addr_o), int'(host_addr_i) & 255);
      if (host_we_i) chk(tag, "ctrl_wdata", int'(ctrl_wdata_o), sw != 0 ? bsw(int'(host_wdata_i)) : int'(host_wdata_i));
    end
    chk(tag, "host_rdata", int'(host_rdata_o), sw != 0 ? bsw(raw) : raw);
    chk(tag, "irq_ack", int'(irq_ack_o), ack);
    ca = int'(cfg_addr_i);
    cexp = (ca < CFG_BYTES) ? ((ca * 7 + 3) & 255) : 0;
    if (ca == 'h2B && m_mode[0] != 0) cexp |= 1;
    if (ca == 'h2F && m_mode[1] != 0) cexp |= 1;
    if (ca == 'h33 && m_mode[2] != 0) cexp |= 1;
    chk(tag, "cfg_rdata", int'(cfg_rdata_o), cexp);
  endtask

  task automatic acc(string tag, int win, bit we, bit s16, int addr, int wd);
    @(negedge clk_i);
    host_req_i = 1'b1; host_win_i = 2'(win); host_we_i = we;
    host_size16_i = s16; host_addr_i = 25'(addr); host_wdata_i = 16'(wd);
    #1 compare(tag);
    @(posedge clk_i);
    #1 host_req_i = 1'b0;
  endtask

  task automatic idle(string tag);
    @(negedge clk_i);
    host_req_i = 1'b0; cfg_we_i = 1'b0;
    #1 compare(tag);
  endtask

  task automatic cfg_wr(string tag, int a, int d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = 7'(a); cfg_wdata_i = 8'(d);
    #1 compare(tag);
    @(posedge clk_i);
    if (a == 'h2B) m_mode[0] = d & 1;
    if (a == 'h2F) m_mode[1] = d & 1;
    if (a == 'h33) m_mode[2] = d & 1;
    #1 cfg_we_i = 1'b0;
  endtask

  task automatic cfg_rd(string tag, int a);
    @(negedge clk_i);
    cfg_addr_i = 7'(a);
    #1 compare(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R10 reset state: mode bits clear
    cfg_rd("R10", 'h2B); cfg_rd("R10", 'h2F); cfg_rd("R10", 'h33);
    idle("R7");
    // R1 I/O window sub-spaces, LE
    acc("R1", 1, 0, 1, 'h1BF, 0);
    acc("R1", 1, 0, 1, 'h27F, 0);
    acc("R1", 1, 1, 0, 'h3D5, 'h0077);
    acc("R1", 1, 0, 0, 'h02A, 0);
    // R2 memory windows
    acc("R2", 2, 0, 1, 'h1ABCDEF, 0);
    acc("R2", 2, 1, 0, 'h0800001, 'h1234);
    acc("R2", 3, 0, 0, 'h0FFFFFF, 0);
    acc("R2", 3, 1, 0, 'h1400010, 'h00AB);
    // R5 size rules
    acc("R5", 0, 0, 0, 'h0C, 0);
    acc("R5", 3, 0, 1, 'h10, 0);
    acc("R5", 3, 1, 1, 'h10, 'h1111);
    // R11 control window
    acc("R11", 0, 0, 1, 'h0C, 0);
    acc("R11", 0, 1, 1, 'h1FE, 'h1234);
    // R7 empty slot
    slot_present_i = 4'b1011;
    acc("R7", 1, 0, 1, 'h200, 0);
    acc("R7", 2, 1, 1, 'h1000000, 'h5555);
    irq_status_i = 8'hFF;
    acc("R7", 1, 0, 0, 'h2C0, 0);
    slot_present_i = 4'hF;
    // R6 acknowledge rules
    irq_status_i = 8'b0000_0101; irq_edge_i = 8'b0000_0100;
    acc("R6", 1, 0, 0, 'h0C0, 0);
    acc("R6", 1, 0, 0, 'h1C0, 0);
    acc("R6", 1, 0, 0, 'h0C2, 0);
    irq_status_i = 8'hFF; irq_edge_i = 8'h00;
    acc("R6", 1, 0, 1, 'h3C2, 0);
    acc("R6", 1, 1, 1, 'h3C2, 'h0);
    acc("R6", 1, 0, 1, 'h3C4, 0);
    acc("R6", 1, 0, 1, 'h302, 0);
    // R8 mode writes
    cfg_wr("R8", 'h2C, 'hFF);
    cfg_rd("R8", 'h2B); cfg_rd("R8", 'h2F); cfg_rd("R8", 'h33);
    cfg_wr("R8", 'h2F, 'h01);
    cfg_rd("R8", 'h2F);
    cfg_wr("R8", 'h2B, 'hFE);
    cfg_rd("R8", 'h2B);
    // R3 BE address flip on byte access
    irq_status_i = 8'h03;
    acc("R3", 1, 0, 0, 'h0C1, 0);
    acc("R3", 1, 0, 0, 'h0C3, 0);
    acc("R3", 1, 1, 0, 'h100, 'h0042);
    // R4 swaps
    acc("R4", 1, 1, 1, 'h004, 'h1234);
    acc("R4", 1, 0, 1, 'h004, 0);
    cfg_wr("R8", 'h33, 'h01);
    cfg_wr("R8", 'h2B, 'h01);
    cfg_rd("R9", 'h33);
    acc("R4", 2, 1, 1, 'h0000010, 'hCAFE);
    acc("R3", 2, 0, 0, 'h0000010, 0);
    acc("R4", 0, 0, 1, 'h0C, 0);
    acc("R4", 0, 1, 1, 'h02, 'hABCD);
    acc("R4", 3, 0, 0, 'h0000011, 0);
    // R9 table reads
    cfg_rd("R9", 0); cfg_rd("R9", 'h57); cfg_rd("R9", 'h58); cfg_rd("R9", 'h7F);
    cfg_rd("R9", 'h2B);
    idle("R7");
    // R10 reset again clears modes
    @(negedge clk_i); rst_ni = 1'b0;
    m_mode = '{0, 0, 0};
    @(negedge clk_i); rst_ni = 1'b1;
    cfg_rd("R10", 'h2F);
    acc("R10", 1, 0, 1, 'h004, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule